// File: doc/BRIEF.md
# Divide-and-Conquer Parallel Prefix Adder

This block is a purely combinational binary adder. It takes two unsigned operands of equal width and returns their sum and a carry-out. Each bit first forms a generate and a propagate term. A prefix tree of log2(W) levels then reduces these terms into a group generate for every bit position. At each level, every bit in the upper half of a block merges with the group that ends at the top bit of the lower half. The sum bits come from the propagate terms and the incoming group carries.

The tree has the fewest logic levels a prefix adder can have. In return, the node at the top of each lower half drives every bit of the upper half, so fanout doubles at each level. The width is a power-of-two parameter with a default of 16. The block has no carry-in. It is meant to be placed between registers, so that the whole sum settles within one clock period.

Top module: `pfx_adder`

## Requirements
- R1: The value {carry_out, sum} equals the full (W+1)-bit arithmetic sum of opnd_a and opnd_b for any operand pair.
- R2: sum bit 0 equals opnd_a bit 0 XOR opnd_b bit 0, because no carry enters bit 0.
- R3: When opnd_b is the bitwise complement of opnd_a, every bit propagates and no bit generates. The sum is then all ones and carry_out is 0.
- R4: All-ones plus 1 wraps around: sum is 0 and carry_out is 1.
- R5: The long-propagation series 0x7FFF, 0x3FFF, 0x1FFF, 0x0FFF, 0x07FF and 0x03FF, each plus 0x0001, gives sum 0x8000, 0x4000, 0x2000, 0x1000, 0x0800 and 0x0400 respectively, with carry_out 0.
- R6: Adding zero leaves the other operand unchanged, and carry_out is 0.
- R7: carry_out is 1 only if the top bit of opnd_a or the top bit of opnd_b is 1.
- R8: Swapping the two operands does not change sum or carry_out.
- R9: The width parameter W must be a power of two and at least 2. It is checked at elaboration. A W=8 instance adds correctly, including 0xFF + 0x01 = 0x00 with carry_out 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | W | First addend |
| opnd_b | input | W | Second addend |
| sum | output | W | Low W bits of the sum |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
Two functions of the block can be active for the same operand pair: the long carry chain through the prefix tree, and the wrap of the carry-out at the top bit. The all-ones-plus-one vector makes both happen together. A carry generated at bit 0 must pass through every tree level to reach both the top sum bit and carry_out. The result is judged against a sum computed one bit wider in the bench. The bit-0 carry series and the complement operands exercise the same merge nodes with the generate present and with it absent. This separates a fault in the generate path of a merge node from a fault in its propagate path.

// File: rtl/pfx_adder_pkg.sv
package pfx_adder_pkg;

   // Elaboration-time legality check for the operand width.
   function automatic bit width_ok(int unsigned w);
      return (w >= 2) && ((w & (w - 1)) == 0);
   endfunction

   // Index of the top bit of the lower half feeding bit i at tree level k.
   function automatic int unsigned feeder_idx(int unsigned i, int unsigned k);
      return ((i >> k) << k) - 1;
   endfunction

endpackage

// File: rtl/pfx_gp_stage.sv
module pfx_gp_stage #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] gen,
   output logic [W-1:0] prop
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign gen[i]  = a[i] & b[i];
      assign prop[i] = a[i] ^ b[i];
   end
endmodule

// File: rtl/pfx_merge_cell.sv
module pfx_merge_cell (
   input  logic hi_g,
   input  logic hi_p,
   input  logic lo_g,
   input  logic lo_p,
   output logic out_g,
   output logic out_p
);
   assign out_g = hi_g | (hi_p & lo_g);
   assign out_p = hi_p & lo_p;
endmodule

// File: rtl/pfx_tree.sv
module pfx_tree #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] g_in,
   input  logic [W-1:0] p_in,
   output logic [W-1:0] g_out,
   output logic [W-1:0] p_out
);
   import pfx_adder_pkg::*;

   localparam int unsigned LEVELS = $clog2(W);

   logic [W-1:0] lvl_g [0:LEVELS];
   logic [W-1:0] lvl_p [0:LEVELS];

   assign lvl_g[0] = g_in;
   assign lvl_p[0] = p_in;

   for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
      for (genvar i = 0; i < W; i++) begin : g_col
         if (((i >> k) & 1) == 1) begin : g_merge
            localparam int unsigned J = feeder_idx(i, k);
            pfx_merge_cell u_cell (
               .hi_g  (lvl_g[k][i]),
               .hi_p  (lvl_p[k][i]),
               .lo_g  (lvl_g[k][J]),
               .lo_p  (lvl_p[k][J]),
               .out_g (lvl_g[k+1][i]),
               .out_p (lvl_p[k+1][i])
            );
         end else begin : g_pass
            assign lvl_g[k+1][i] = lvl_g[k][i];
            assign lvl_p[k+1][i] = lvl_p[k][i];
         end
      end
   end

   assign g_out = lvl_g[LEVELS];
   assign p_out = lvl_p[LEVELS];
endmodule

// File: rtl/pfx_sum_stage.sv
module pfx_sum_stage #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] prop,
   input  logic [W-1:0] grp_g,
   output logic [W-1:0] sum,
   output logic         cout
);
   assign sum[0] = prop[0];
   for (genvar i = 1; i < W; i++) begin : g_sum
      assign sum[i] = prop[i] ^ grp_g[i-1];
   end
   assign cout = grp_g[W-1];
endmodule

// File: rtl/pfx_adder.sv
module pfx_adder #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] opnd_a,
   input  logic [W-1:0] opnd_b,
   output logic [W-1:0] sum,
   output logic         carry_out
);
   import pfx_adder_pkg::*;

   if (!width_ok(W)) begin : g_bad_width
      $error("pfx_adder: W must be a power of two and at least 2");
   end

   logic [W-1:0] bit_g, bit_p, grp_g, grp_p;

   pfx_gp_stage #(.W(W)) u_gp (
      .a    (opnd_a),
      .b    (opnd_b),
      .gen  (bit_g),
      .prop (bit_p)
   );

   pfx_tree #(.W(W)) u_tree (
      .g_in  (bit_g),
      .p_in  (bit_p),
      .g_out (grp_g),
      .p_out (grp_p)
   );

   pfx_sum_stage #(.W(W)) u_sum (
      .prop  (bit_p),
      .grp_g (grp_g),
      .sum   (sum),
      .cout  (carry_out)
   );

   logic unused_grp_p;
   assign unused_grp_p = ^grp_p;
endmodule

// File: rtl/pfx_adder_chk.sv
module pfx_adder_chk #(
   parameter int unsigned W = 16
) (
   input logic [W-1:0] a,
   input logic [W-1:0] b,
   input logic [W-1:0] s,
   input logic         co
);
   logic [W:0] ref_sum;
   assign ref_sum = {1'b0, a} + {1'b0, b};

   always_comb begin
      if (!$isunknown({a, b, s, co})) begin
         assert_full_sum_R1: assert ({co, s} == ref_sum)
            else $error("R1 sum mismatch");
         assert_bit0_R2: assert (s[0] == (a[0] ^ b[0]))
            else $error("R2 bit0 mismatch");
         if (b == ~a) begin
            assert_complement_R3: assert ((s == {W{1'b1}}) && !co)
               else $error("R3 complement mismatch");
         end
         if (b == '0) begin
            assert_add_zero_R6: assert ((s == a) && !co)
               else $error("R6 add-zero mismatch");
         end
         if (co) begin
            assert_cout_msb_R7: assert (a[W-1] | b[W-1])
               else $error("R7 carry without top bit");
         end
      end
   end
endmodule

bind pfx_adder pfx_adder_chk #(.W(W)) u_chk (
   .a  (opnd_a),
   .b  (opnd_b),
   .s  (sum),
   .co (carry_out)
);

// File: tb/tb_pfx_adder.sv
module tb_pfx_adder;
   localparam int unsigned W = 16;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk;

   logic [W-1:0] a = '0, b = '0, s;
   logic         co;
   logic [7:0]   a8 = '0, b8 = '0, s8;
   logic         co8;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   pfx_adder #(.W(W)) dut (.opnd_a(a), .opnd_b(b), .sum(s), .carry_out(co));
   pfx_adder #(.W(8))  dut8 (.opnd_a(a8), .opnd_b(b8), .sum(s8), .carry_out(co8));

   task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input string req);
      logic [W:0] exp;
      @(negedge clk);
      a = x; b = y;
      #2;
      exp = {1'b0, x} + {1'b0, y};
      checks++;
      if ({co, s} !== exp) begin
         failures++;
         $display("FAIL %s a=%h b=%h actual=%h expected=%h", req, x, y, {co, s}, exp);
      end
   endtask

   task automatic t_reset_state();  // R6: zero inputs
      apply('0, '0, "R6");
   endtask

   task automatic t_bit0();         // R2
      apply(16'h0001, 16'h0000, "R2");
      apply(16'h0001, 16'h0001, "R2");
      checks++;
      if (s[0] !== 1'b0) begin
         failures++;
         $display("FAIL R2 s0 actual=%b expected=0", s[0]);
      end
   endtask

   task automatic t_complement();   // R3
      logic [W-1:0] pats [4] = '{16'h0000, 16'hA5A5, 16'h00FF, 16'h1234};
      foreach (pats[n]) begin
         apply(pats[n], ~pats[n], "R3");
         checks++;
         if (s !== 16'hFFFF || co !== 1'b0) begin
            failures++;
            $display("FAIL R3 actual=%h expected=0ffff", {co, s});
         end
      end
   endtask

   task automatic t_wrap();         // R4
      apply(16'hFFFF, 16'h0001, "R4");
      checks++;
      if (s !== 16'h0000 || co !== 1'b1) begin
         failures++;
         $display("FAIL R4 actual=%h expected=10000", {co, s});
      end
   endtask

   task automatic t_series();       // R5
      for (int k = 15; k >= 10; k--) begin
         logic [W-1:0] op;
         op = (16'h1 << k) - 16'h1;
         apply(op, 16'h0001, "R5");
         checks++;
         if (s !== (16'h1 << k) || co !== 1'b0) begin
            failures++;
            $display("FAIL R5 actual=%h expected=%h", {co, s}, {1'b0, 16'h1 << k});
         end
      end
   endtask

   task automatic t_zero();         // R6
      apply(16'hBEEF, 16'h0000, "R6");
      checks++;
      if (s !== 16'hBEEF || co !== 1'b0) begin
         failures++;
         $display("FAIL R6 actual=%h expected=0beef", {co, s});
      end
   endtask

   task automatic t_msb();          // R7
      apply(16'h7FFF, 16'h7FFF, "R7");
      checks++;
      if (co !== 1'b0) begin
         failures++;
         $display("FAIL R7 actual=%b expected=0", co);
      end
      apply(16'h8000, 16'h8000, "R7");
   endtask

   task automatic t_commute();      // R8
      logic [W:0] first;
      apply(16'h9C3B, 16'h6E71, "R8");
      first = {co, s};
      apply(16'h6E71, 16'h9C3B, "R8");
      checks++;
      if ({co, s} !== first) begin
         failures++;
         $display("FAIL R8 actual=%h expected=%h", {co, s}, first);
      end
   endtask

   task automatic t_random();       // R1
      for (int n = 0; n < 400; n++) begin
         apply(W'($urandom), W'($urandom), "R1");
      end
      for (int k = 0; k < W; k++) begin
         apply(16'hFFFF >> (W - 1 - k), 16'h1, "R1");
      end
   endtask

   task automatic t_width8();       // R9
      for (int n = 0; n < 64; n++) begin
         logic [7:0] x, y;
         logic [8:0] exp;
         x = (n == 0) ? 8'hFF : 8'($urandom);
         y = (n == 0) ? 8'h01 : 8'($urandom);
         @(negedge clk);
         a8 = x; b8 = y;
         #2;
         exp = {1'b0, x} + {1'b0, y};
         checks++;
         if ({co8, s8} !== exp) begin
            failures++;
            $display("FAIL R9 a=%h b=%h actual=%h expected=%h", x, y, {co8, s8}, exp);
         end
      end
   endtask

   initial begin
      repeat (2) @(posedge clk);
      rst = 1'b0;
      t_reset_state();
      t_bit0();
      t_complement();
      t_wrap();
      t_series();
      t_zero();
      t_msb();
      t_commute();
      t_random();
      t_width8();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int cyc = 0; cyc < 20000; cyc++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule